// File: doc/BRIEF.md
# Descrambler Lock Confidence Tracker

This block decides whether a self-synchronising cell descrambler is in lock. Once per cell the header check logic gives it a single-cycle strobe that says whether the predicted header check matched. The block keeps one confidence counter. The lock state sets which kind of prediction moves that counter toward a change of state.

Out of lock, good predictions raise the counter and bad ones lower it. When the raised value reaches the programmable gain threshold, the block declares lock. In lock the roles swap. Bad predictions raise the counter, good ones lower it, and reaching the programmable loss threshold drops lock. Every change of state clears the counter in the same cycle, so each state starts its count from zero. Both thresholds are 4 bits wide and can be set separately. The lock flag and the live count are outputs.

Top module: `desc_lock_tracker`

## Requirements
- R1: After reset the block is out of lock (`locked` = 0) and `conf_cnt` is 0.
- R2: Out of lock, a strobe with `pred_good` = 1 raises `conf_cnt` by one, and a strobe with `pred_good` = 0 lowers it by one. The new value appears on the clock edge that samples the strobe.
- R3: In lock, a strobe with `pred_good` = 0 raises `conf_cnt` by one, and a strobe with `pred_good` = 1 lowers it by one.
- R4: A lowering strobe while `conf_cnt` is 0 leaves the count at 0 and does not change `locked`.
- R5: Out of lock, a raising strobe whose raised value is at least `gain_thr` sets `locked` to 1 and clears `conf_cnt` to 0 on that same edge.
- R6: In lock, a raising strobe whose raised value is at least `loss_thr` clears `locked` to 0 and clears `conf_cnt` to 0 on that same edge.
- R7: In a cycle with `pred_valid` = 0, neither `conf_cnt` nor `locked` changes.
- R8: A threshold of 0 or 1 changes the state on the first raising strobe in that state.
- R9: Only the threshold of the current state is used. `loss_thr` has no effect out of lock, and `gain_thr` has no effect in lock. A threshold of 15 needs fifteen net raising strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_valid | input | 1 | Single-cycle strobe: one header check prediction result |
| pred_good | input | 1 | Qualifier of the strobe: 1 = prediction matched |
| gain_thr | input | THR_W | Count needed to enter lock |
| loss_thr | input | THR_W | Count needed to leave lock |
| locked | output | 1 | 1 = descrambler in lock |
| conf_cnt | output | THR_W | Current confidence count |

## Verification
The bench builds the block with the default `THR_W` = 4, so the full threshold range from 0 to 15 is reachable. Directed runs use a small gain threshold, a mid loss threshold, both extremes 0 and 15, and thresholds changed while the other state is active. With these values the bench reaches the zero floor, the same-edge clear on each state change, and a count of 14 just before lock is gained at 15.

// File: rtl/desc_lock_pkg.sv
package desc_lock_pkg;

  typedef enum logic {
    ST_HUNT   = 1'b0,
    ST_LOCKED = 1'b1
  } lock_st_e;

  typedef enum logic [1:0] {
    MV_HOLD = 2'd0,
    MV_UP   = 2'd1,
    MV_DOWN = 2'd2
  } move_e;

endpackage

// File: rtl/conf_move_dec.sv
module conf_move_dec
  import desc_lock_pkg::*;
(
  input  logic     pred_valid,
  input  logic     pred_good,
  input  lock_st_e state,
  output move_e    move
);

  logic toward_change;

  // Out of lock a good prediction pushes toward a change; in lock a bad one does.
  assign toward_change = (state == ST_HUNT) ? pred_good : ~pred_good;

  always_comb begin
    if (!pred_valid) begin
      move = MV_HOLD;
    end else if (toward_change) begin
      move = MV_UP;
    end else begin
      move = MV_DOWN;
    end
  end

endmodule

// File: rtl/conf_counter.sv
module conf_counter
  import desc_lock_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  move_e        move,
  input  logic         clear,
  output logic [W-1:0] cnt,
  output logic [W:0]   cnt_inc
);

  logic [W-1:0] cnt_d;
  logic         cnt_en;

  assign cnt_inc = {1'b0, cnt} + {{W{1'b0}}, 1'b1};

  always_comb begin
    cnt_d  = cnt;
    cnt_en = 1'b0;
    if (clear) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else begin
      unique case (move)
        MV_UP: begin
          if (!cnt_inc[W]) begin
            cnt_d  = cnt_inc[W-1:0];
            cnt_en = 1'b1;
          end
        end
        MV_DOWN: begin
          if (cnt != '0) begin
            cnt_d  = cnt - {{(W-1){1'b0}}, 1'b1};
            cnt_en = 1'b1;
          end
        end
        default: begin
          cnt_en = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_en) begin
      cnt <= cnt_d;
    end
  end

endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
  import desc_lock_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  move_e        move,
  input  logic [W:0]   cnt_inc,
  input  logic [W-1:0] gain_thr,
  input  logic [W-1:0] loss_thr,
  output lock_st_e     state,
  output logic         flip
);

  logic [W-1:0] active_thr;
  lock_st_e     state_d;

  assign active_thr = (state == ST_HUNT) ? gain_thr : loss_thr;
  assign flip       = (move == MV_UP) && (cnt_inc >= {1'b0, active_thr});

  always_comb begin
    state_d = state;
    if (flip) begin
      state_d = (state == ST_HUNT) ? ST_LOCKED : ST_HUNT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_HUNT;
    end else if (flip) begin
      state <= state_d;
    end
  end

endmodule

// File: rtl/desc_lock_tracker.sv
module desc_lock_tracker
  import desc_lock_pkg::*;
#(
  parameter int unsigned THR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pred_valid,
  input  logic             pred_good,
  input  logic [THR_W-1:0] gain_thr,
  input  logic [THR_W-1:0] loss_thr,
  output logic             locked,
  output logic [THR_W-1:0] conf_cnt
);

  lock_st_e       state;
  move_e          move;
  logic           flip;
  logic [THR_W:0] cnt_inc;

  conf_move_dec u_dec (
    .pred_valid (pred_valid),
    .pred_good  (pred_good),
    .state      (state),
    .move       (move)
  );

  conf_counter #(.W(THR_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .move    (move),
    .clear   (flip),
    .cnt     (conf_cnt),
    .cnt_inc (cnt_inc)
  );

  lock_fsm #(.W(THR_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .move     (move),
    .cnt_inc  (cnt_inc),
    .gain_thr (gain_thr),
    .loss_thr (loss_thr),
    .state    (state),
    .flip     (flip)
  );

  assign locked = (state == ST_LOCKED);

endmodule

// File: rtl/desc_lock_tracker_chk.sv
module desc_lock_tracker_chk #(
  parameter int unsigned THR_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pred_valid,
  input logic             pred_good,
  input logic [THR_W-1:0] gain_thr,
  input logic [THR_W-1:0] loss_thr,
  input logic             locked,
  input logic [THR_W-1:0] conf_cnt
);

  logic [THR_W:0] raised;
  assign raised = {1'b0, conf_cnt} + {{THR_W{1'b0}}, 1'b1};

  // R2: below the gain threshold a good strobe raises the count by one
  a_r2_hunt_up: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && pred_valid && pred_good && raised < {1'b0, gain_thr})
      |=> (!locked && {1'b0, conf_cnt} == $past(raised)));

  // R3: below the loss threshold a bad strobe in lock raises the count by one
  a_r3_lock_up: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && pred_valid && !pred_good && raised < {1'b0, loss_thr})
      |=> (locked && {1'b0, conf_cnt} == $past(raised)));

  // R4: a lowering strobe at zero keeps the count and the state
  a_r4_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_valid && (pred_good == locked) && conf_cnt == '0)
      |=> (conf_cnt == '0 && $stable(locked)));

  // R5: reaching the gain threshold enters lock with a cleared count
  a_r5_gain: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && pred_valid && pred_good && raised >= {1'b0, gain_thr})
      |=> (locked && conf_cnt == '0));

  // R6: reaching the loss threshold leaves lock with a cleared count
  a_r6_loss: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && pred_valid && !pred_good && raised >= {1'b0, loss_thr})
      |=> (!locked && conf_cnt == '0));

  // R7: no strobe, no change
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_valid |=> ($stable(conf_cnt) && $stable(locked)));

endmodule

bind desc_lock_tracker desc_lock_tracker_chk #(.THR_W(THR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pred_valid (pred_valid),
  .pred_good  (pred_good),
  .gain_thr   (gain_thr),
  .loss_thr   (loss_thr),
  .locked     (locked),
  .conf_cnt   (conf_cnt)
);

// File: tb/desc_lock_tracker_tb.sv
module desc_lock_tracker_tb;

  localparam int THR_W = 4;

  logic             clk;
  logic             rst_n;
  logic             pred_valid;
  logic             pred_good;
  logic [THR_W-1:0] gain_thr;
  logic [THR_W-1:0] loss_thr;
  logic             locked;
  logic [THR_W-1:0] conf_cnt;

  int checks;
  int errors;
  int m_cnt;
  bit m_lock;

  desc_lock_tracker #(.THR_W(THR_W)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .pred_valid (pred_valid),
    .pred_good  (pred_good),
    .gain_thr   (gain_thr),
    .loss_thr   (loss_thr),
    .locked     (locked),
    .conf_cnt   (conf_cnt)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(string req, int exp_cnt, bit exp_lock);
    checks++;
    if (int'(conf_cnt) != exp_cnt || locked != exp_lock) begin
      errors++;
      $display("FAIL %s: actual cnt=%0d locked=%0b, expected cnt=%0d locked=%0b",
               req, conf_cnt, locked, exp_cnt, exp_lock);
    end
  endtask

  // Independent reference of the requirements
  task automatic model(bit good);
    int thr;
    bit up;
    thr = m_lock ? int'(loss_thr) : int'(gain_thr);
    up  = m_lock ? !good : good;
    if (up) begin
      if (m_cnt + 1 >= thr) begin
        m_lock = !m_lock;
        m_cnt  = 0;
      end else begin
        m_cnt = m_cnt + 1;
      end
    end else if (m_cnt > 0) begin
      m_cnt = m_cnt - 1;
    end
  endtask

  // Drive one strobe at a falling edge; results are sampled at the next falling edge
  task automatic strobe(bit good);
    @(negedge clk);
    pred_valid = 1'b1;
    pred_good  = good;
    model(good);
    @(negedge clk);
    pred_valid = 1'b0;
  endtask

  task automatic do_reset();
    pred_valid = 1'b0;
    pred_good  = 1'b0;
    rst_n      = 1'b0;
    m_cnt      = 0;
    m_lock     = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    gain_thr = 4'd3; loss_thr = 4'd3;
    do_reset();
    check("R1 reset state", 0, 1'b0);
  endtask

  task automatic t_gain();
    do_reset();
    gain_thr = 4'd3; loss_thr = 4'd4;
    strobe(1'b1); check("R2 hunt good raises", 1, 1'b0);
    strobe(1'b0); check("R2 hunt bad lowers", 0, 1'b0);
    strobe(1'b1); strobe(1'b1); check("R2 hunt count two", 2, 1'b0);
    strobe(1'b1); check("R5 gain reached, cleared", 0, 1'b1);
  endtask

  task automatic t_loss();
    // continues in lock from t_gain, loss_thr = 4
    strobe(1'b0); check("R3 lock bad raises", 1, 1'b1);
    strobe(1'b0); check("R3 lock bad raises again", 2, 1'b1);
    strobe(1'b1); check("R3 lock good lowers", 1, 1'b1);
    strobe(1'b0); strobe(1'b0); check("R3 lock count three", 3, 1'b1);
    strobe(1'b0); check("R6 loss reached, cleared", 0, 1'b0);
    check("R6 model agrees", m_cnt, m_lock);
  endtask

  task automatic t_floor();
    do_reset();
    gain_thr = 4'd2; loss_thr = 4'd2;
    strobe(1'b0); strobe(1'b0); check("R4 hunt floor at zero", 0, 1'b0);
    strobe(1'b1); strobe(1'b1); check("R5 lock after floor", 0, 1'b1);
    strobe(1'b1); check("R4 lock floor at zero", 0, 1'b1);
  endtask

  task automatic t_hold();
    do_reset();
    gain_thr = 4'd5; loss_thr = 4'd5;
    strobe(1'b1); strobe(1'b1);
    @(negedge clk); pred_good = 1'b1;
    repeat (6) @(negedge clk);
    check("R7 hold without strobe", 2, 1'b0);
    pred_good = 1'b0;
  endtask

  task automatic t_zero_thr();
    do_reset();
    gain_thr = 4'd0; loss_thr = 4'd1;
    strobe(1'b0); check("R8 lowering at zero does not lock", 0, 1'b0);
    strobe(1'b1); check("R8 gain threshold 0 locks at once", 0, 1'b1);
    strobe(1'b1); check("R8 lowering at zero keeps lock", 0, 1'b1);
    strobe(1'b0); check("R8 loss threshold 1 unlocks at once", 0, 1'b0);
  endtask

  task automatic t_indep();
    do_reset();
    gain_thr = 4'd15; loss_thr = 4'd0;
    for (int i = 0; i < 14; i++) strobe(1'b1);
    check("R9 loss_thr ignored out of lock", 14, 1'b0);
    strobe(1'b1); check("R9 gain at fifteen", 0, 1'b1);
    gain_thr = 4'd0; loss_thr = 4'd2;
    strobe(1'b1); check("R9 gain_thr ignored in lock", 0, 1'b1);
    strobe(1'b0); check("R9 loss count one", 1, 1'b1);
    strobe(1'b0); check("R9 loss at two", 0, 1'b0);
    check("R9 model agrees", m_cnt, m_lock);
  endtask

  initial begin
    checks = 0;
    errors = 0;
    rst_n = 1'b0;
    pred_valid = 1'b0;
    pred_good = 1'b0;
    gain_thr = '0;
    loss_thr = '0;
    t_reset();
    t_gain();
    t_loss();
    t_floor();
    t_hold();
    t_zero_thr();
    t_indep();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual run still going, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule